// File: doc/BRIEF.md
# System Tick Timer

A 24-bit periodic down-counter with a word-wide register window. Software loads a reload value, picks the count source and turns the counter on. The counter then runs from the reload value down to zero again and again. Each time it goes from one to zero it sets a sticky flag and, when interrupts are enabled, drives a one-cycle interrupt pulse toward an interrupt controller. The count source is either every core clock cycle or each core cycle in which a qualified reference-tick enable input is high.

Every access is one cycle wide. Read data and the error response are combinational in the cycle of the request, and any change of state takes effect at the clock edge that closes the request. Two kinds of access are refused with an error and change nothing: an access without the privilege attribute, and an access that is not a full word. A fixed calibration word is built from parameters. It gives the number of reference ticks in ten milliseconds and says whether that number is exact, or whether there is no reference clock at all.

Top module: `tick_timer`

## Requirements
- R1: An access with `req_word` low gets `rsp_err` high, returns zero read data and changes no state.
- R2: Offset 0x0 is control/status: bit 0 enable, bit 1 interrupt enable, bit 2 source select (1 = every core cycle, 0 = cycles with `ref_tick` high) and bit 16 the sticky flag. All other bits read zero, and a write changes only bits [2:0].
- R3: Reading offset 0x0 returns the present value and then clears the flag. An expiry at the same edge leaves the flag set.
- R4: Offset 0x4 is the reload value. Only write bits [23:0] are stored, and bits [31:24] read zero.
- R5: Any write to offset 0x8 sets the count to zero and clears the flag. Such a write stops the counter if the reload value is zero.
- R6: While running, the count at offset 0x8 drops by one on each count edge. A count edge is every cycle when bit 2 is 1, or every cycle with `ref_tick` high when bit 2 is 0. The counter starts on the edge after a write that changes enable from 0 to 1, and it stops when a write changes enable from 1 to 0.
- R7: Expiry is a decrement from 1 to 0. It sets the flag and, when bit 1 is set, drives `irq_pulse` high for exactly the one cycle after that edge.
- R8: A count of zero loads the reload value at the next count edge without setting the flag.
- R9: An expiry with a zero reload value stops counting while enable still reads 1. Writing enable as 1 again does not restart the counter; writing 0 and then 1 does.
- R10: With `HAS_REF` = 0, bit 2 of control/status reads 1 at all times, from reset on.
- R11: Offset 0xC reads bit 31 = no reference clock, bit 30 = ten-millisecond count inexact, and bits [23:0] = floor(`REF_HZ`/100) − 1. With no reference clock only bit 31 is set. The default gives 0x4000_0146.
- R12: An access with `req_priv` low gets `rsp_err` high and changes no state.
- R13: After reset, control/status, reload and count read zero (apart from a forced bit 2), `irq_pulse` is low and the counter is stopped.
- R14: A read of any offset other than 0x0, 0x4, 0x8 and 0xC returns zero, a write there changes nothing, and neither access raises `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Qualified reference-tick enable, one core cycle per tick |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Privileged access attribute |
| req_word | input | 1 | Access is a full 32-bit word |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the request cycle |
| rsp_err | output | 1 | Error response, valid in the request cycle |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions take it that a request lasts one cycle and that `ref_tick` is already synchronous to `clk`. They also take it that no two accesses to the window overlap, so a current-value write never falls in the same cycle as a control read. The stimulus drives at most one request per cycle, changes every input only at the falling edge, and keeps random reload values small so that expiries, reloads from zero and zero-reload halts all happen often. Unprivileged, sub-word and unmapped accesses are mixed in among the legal ones.

// File: rtl/tick_timer_pkg.sv
// Shared definitions of the system tick timer: register selects, field
// positions and the calibration word built from parameters.
package tick_timer_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_CALIB   = 2'd3
    } reg_sel_e;

    localparam int BIT_EN    = 0;
    localparam int BIT_IE    = 1;
    localparam int BIT_SRC   = 2;
    localparam int BIT_FLAG  = 16;
    localparam int BIT_NOREF = 31;
    localparam int BIT_SKEW  = 30;

    // Calibration word: ticks per ten milliseconds minus one, plus exactness and presence bits.
    function automatic logic [31:0] calib_word(input bit has_ref, input longint unsigned ref_hz);
        logic [31:0]     w;
        longint unsigned ticks;
        w = '0;
        if (!has_ref) begin
            w[BIT_NOREF] = 1'b1;
        end else begin
            ticks    = ref_hz / 100;
            w[23:0]  = 24'(ticks - 1);
            if ((ticks * 100) != ref_hz || ticks == 0 || (ticks - 1) > 64'hFF_FFFF) begin
                w[BIT_SKEW] = 1'b1;
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/tick_timer_bus.sv
// Register window decode for the system tick timer.
// Assumes one single-cycle request at a time. It returns combinational read
// data and error, and it raises one write or read strobe only for an access
// that is privileged, full-word and mapped.
module tick_timer_bus
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 24
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       ctrl_word,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [CNT_W-1:0]  count_val,
    input  logic [31:0]       calib_val,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              rd_ctrl,
    output logic              wr_ctrl,
    output logic              wr_reload,
    output logic              wr_current
);

    localparam int PAD_W = 32 - CNT_W;

    logic     allowed;
    logic     mapped;
    reg_sel_e sel;

    // Classify the access: allowed attributes, and whether the offset hits a register.
    always_comb begin
        allowed = req_valid && req_priv && req_word;
        mapped  = ((req_addr >> 4) == '0) && (req_addr[1:0] == 2'b00);
        sel     = reg_sel_e'(req_addr[3:2]);
        rsp_err = req_valid && !(req_priv && req_word);
    end

    // Raise the per-register strobes for accepted accesses.
    always_comb begin
        rd_ctrl    = allowed && mapped && !req_write && (sel == SEL_CTRL);
        wr_ctrl    = allowed && mapped &&  req_write && (sel == SEL_CTRL);
        wr_reload  = allowed && mapped &&  req_write && (sel == SEL_RELOAD);
        wr_current = allowed && mapped &&  req_write && (sel == SEL_CURRENT);
    end

    // Select read data; anything refused, unmapped or written reads as zero.
    always_comb begin
        rsp_rdata = '0;
        if (allowed && mapped && !req_write) begin
            case (sel)
                SEL_CTRL:    rsp_rdata = ctrl_word;
                SEL_RELOAD:  rsp_rdata = {{PAD_W{1'b0}}, reload_val};
                SEL_CURRENT: rsp_rdata = {{PAD_W{1'b0}}, count_val};
                default:     rsp_rdata = calib_val;
            endcase
        end
    end

endmodule

// File: rtl/tick_timer_ctrl.sv
// Control/status state of the system tick timer: enable, interrupt enable,
// source select and the sticky expiry flag. It turns enable transitions into
// start and stop commands. It assumes expire is already suppressed for a
// cycle that holds a current-value write.
module tick_timer_ctrl
    import tick_timer_pkg::*;
#(
    parameter bit HAS_REF = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       rd_ctrl,
    input  logic       wr_current,
    input  logic [2:0] wdata,
    input  logic       expire,
    output logic       en,
    output logic       ie,
    output logic       use_core,
    output logic       flag,
    output logic       run_on,
    output logic       run_off
);

    localparam logic SRC_RESET = !HAS_REF;

    // Start on an enable 0->1 write and stop on an enable 1->0 write.
    always_comb begin
        run_on  = wr_ctrl &&  wdata[BIT_EN] && !en;
        run_off = wr_ctrl && !wdata[BIT_EN] &&  en;
    end

    // Hold the writable control bits; the source bit is forced high without a reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            ie       <= 1'b0;
            use_core <= SRC_RESET;
        end else if (wr_ctrl) begin
            en       <= wdata[BIT_EN];
            ie       <= wdata[BIT_IE];
            use_core <= wdata[BIT_SRC] || !HAS_REF;
        end
    end

    // Sticky flag: set on expiry, cleared by a status read or a current-value write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (rd_ctrl || wr_current) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tick_timer_counter.sv
// Down-counter, reload register and run state of the system tick timer.
// Assumes ref_tick is synchronous to clk and that start, stop and the
// register writes come in from a single access at a time.
module tick_timer_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             use_core,
    input  logic             ie,
    input  logic             run_on,
    input  logic             run_off,
    input  logic             wr_reload,
    input  logic             wr_current,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             running,
    output logic             expire,
    output logic             irq_pulse
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic count_edge;
    logic reload_zero;

    // Qualify the count edge and detect expiry, which a current-value write suppresses.
    always_comb begin
        count_edge  = running && (use_core || ref_tick);
        reload_zero = (reload == '0);
        expire      = count_edge && (count == ONE) && !wr_current;
    end

    // Reload register: keep only the low count bits of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (wr_reload) begin
            reload <= wdata;
        end
    end

    // Count: zero on a current-value write, reload at zero, otherwise decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_current) begin
            count <= '0;
        end else if (count_edge) begin
            if (count == '0) begin
                count <= reload;
            end else begin
                count <= count - ONE;
            end
        end
    end

    // Run state: enable commands take priority, then the zero-reload halts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (run_off) begin
            running <= 1'b0;
        end else if (run_on) begin
            running <= 1'b1;
        end else if ((wr_current || expire) && reload_zero) begin
            running <= 1'b0;
        end
    end

    // Interrupt request: one cycle after an expiry with interrupts enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= expire && ie;
        end
    end

endmodule

// File: rtl/tick_timer.sv
// System tick timer top: register window, control state, counter and
// calibration constant. Assumes a single synchronous clock domain, with
// ref_tick already qualified into that domain.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter bit          HAS_REF = 1'b1,
    parameter int unsigned REF_HZ  = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              irq_pulse
);

    localparam int          CNT_W     = 24;
    localparam logic [31:0] CALIB_VAL = calib_word(HAS_REF, longint'(REF_HZ));

    logic             rd_ctrl, wr_ctrl, wr_reload, wr_current;
    logic             st_en, st_ie, st_core, st_flag;
    logic             run_on, run_off, st_running, expire;
    logic [CNT_W-1:0] cnt_val, rld_val;
    logic [31:0]      ctrl_word;

    // Assemble the control/status read word from its fields.
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_EN]   = st_en;
        ctrl_word[BIT_IE]   = st_ie;
        ctrl_word[BIT_SRC]  = st_core;
        ctrl_word[BIT_FLAG] = st_flag;
    end

    tick_timer_bus #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bus (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_priv   (req_priv),
        .req_word   (req_word),
        .req_addr   (req_addr),
        .ctrl_word  (ctrl_word),
        .reload_val (rld_val),
        .count_val  (cnt_val),
        .calib_val  (CALIB_VAL),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err),
        .rd_ctrl    (rd_ctrl),
        .wr_ctrl    (wr_ctrl),
        .wr_reload  (wr_reload),
        .wr_current (wr_current)
    );

    tick_timer_ctrl #(.HAS_REF(HAS_REF)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .rd_ctrl    (rd_ctrl),
        .wr_current (wr_current),
        .wdata      (req_wdata[2:0]),
        .expire     (expire),
        .en         (st_en),
        .ie         (st_ie),
        .use_core   (st_core),
        .flag       (st_flag),
        .run_on     (run_on),
        .run_off    (run_off)
    );

    tick_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .use_core   (st_core),
        .ie         (st_ie),
        .run_on     (run_on),
        .run_off    (run_off),
        .wr_reload  (wr_reload),
        .wr_current (wr_current),
        .wdata      (req_wdata[CNT_W-1:0]),
        .count      (cnt_val),
        .reload     (rld_val),
        .running    (st_running),
        .expire     (expire),
        .irq_pulse  (irq_pulse)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Property checker for the system tick timer, bound into every instance of
// the top. Assumes single-cycle requests and a synchronous ref_tick.
module tick_timer_chk #(
    parameter int ADDR_W  = 8,
    parameter bit HAS_REF = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_priv,
    input logic              req_word,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic              irq_pulse,
    input logic              st_flag,
    input logic              st_running,
    input logic              wr_current,
    input logic [23:0]       cnt_val,
    input logic [23:0]       rld_val
);

    logic good_rd;
    assign good_rd = req_valid && req_priv && req_word && !req_write;

    p_refused_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_priv && req_word)) |-> rsp_err);

    p_refused_keeps_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_priv && req_word)) |=> $stable(rld_val));

    p_unmapped_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (good_rd && ((req_addr >> 4) != '0)) |-> (!rsp_err && rsp_rdata == 32'h0));

    p_reload_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (good_rd && req_addr == ADDR_W'(4)) |-> (rsp_rdata[31:24] == 8'h00));

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_irq_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> st_flag);

    p_current_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_current |=> (cnt_val == 24'h0 && !st_flag));

    p_stopped_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_running && !wr_current) |=> $stable(cnt_val));

    p_src_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_REF && good_rd && req_addr == '0) |-> rsp_rdata[2]);

endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .HAS_REF(HAS_REF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_priv   (req_priv),
    .req_word   (req_word),
    .req_addr   (req_addr),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .irq_pulse  (irq_pulse),
    .st_flag    (st_flag),
    .st_running (st_running),
    .wr_current (wr_current),
    .cnt_val    (cnt_val),
    .rld_val    (rld_val)
);

// File: tb/test_tick_timer.sv
// Bench for the system tick timer: directed corner cases, then seeded random
// accesses, all compared against a behavioural model kept in the bench.
module test_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b1, req_word = 1'b1;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata, nr_rdata;
    logic        rsp_err, irq_pulse, nr_err, nr_irq;

    int checks = 0;
    int errors = 0;

    // bench model state
    bit        m_en, m_ie, m_cs, m_flag, m_run, m_irq;
    bit [23:0] m_cnt, m_rld;
    logic [31:0] nr_last;

    always #10 clk = ~clk;

    tick_timer #(.ADDR_W(8), .HAS_REF(1'b1), .REF_HZ(32768)) i_tick_timer (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .req_valid(req_valid), .req_write(req_write), .req_priv(req_priv),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_pulse(irq_pulse)
    );

    tick_timer #(.ADDR_W(8), .HAS_REF(1'b0), .REF_HZ(32768)) i_tick_timer_noref (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .req_valid(req_valid), .req_write(req_write), .req_priv(req_priv),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(nr_rdata), .rsp_err(nr_err), .irq_pulse(nr_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected read data from the requirements (R2, R4, R6, R11, R14).
    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00:   return {15'b0, m_flag, 13'b0, m_cs, m_ie, m_en};
            8'h04:   return {8'b0, m_rld};
            8'h08:   return {8'b0, m_cnt};
            8'h0C:   return 32'h4000_0146;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:   return "R3";
            8'h04:   return "R4";
            8'h08:   return "R6";
            8'h0C:   return "R11";
            default: return "R14";
        endcase
    endfunction

    // Advance the model across one clock edge.
    task automatic m_edge(input bit v, w, p, wd, input logic [7:0] a, input logic [31:0] d, input bit rt);
        bit ok, edge_on, exp_hit, n_run, n_flag;
        bit [23:0] n_cnt;
        ok      = v && p && wd;
        edge_on = m_run && (m_cs || rt);
        exp_hit = 1'b0;
        n_cnt   = m_cnt;
        n_run   = m_run;
        n_flag  = m_flag;
        if (edge_on) begin
            if (m_cnt == 0) n_cnt = m_rld;
            else begin
                n_cnt = m_cnt - 1;
                if (m_cnt == 1) begin
                    exp_hit = 1'b1;
                    if (m_rld == 0) n_run = 1'b0;
                end
            end
        end
        if (ok && !w && a == 8'h00) n_flag = 1'b0;
        if (ok && w && a == 8'h08) begin
            n_cnt = 0; exp_hit = 1'b0; n_flag = 1'b0;
            if (m_rld == 0) n_run = 1'b0;
        end
        if (exp_hit) n_flag = 1'b1;
        m_irq = exp_hit && m_ie;
        if (ok && w && a == 8'h00) begin
            if (d[0] != m_en) n_run = d[0];
            m_en = d[0]; m_ie = d[1]; m_cs = d[2];
        end
        if (ok && w && a == 8'h04) m_rld = d[23:0];
        m_cnt = n_cnt; m_run = n_run; m_flag = n_flag;
    endtask

    // One bus cycle: drive at the falling edge, sample, update the model, pass the rising edge.
    task automatic cyc(input string tag, input bit v, w, p, wd, input logic [7:0] a,
                       input logic [31:0] d, input bit rt);
        req_valid = v; req_write = w; req_priv = p; req_word = wd;
        req_addr = a; req_wdata = d; ref_tick = rt;
        #2;
        nr_last = nr_rdata;
        check("R7", {31'b0, irq_pulse}, {31'b0, m_irq});
        if (v) begin
            check((p && wd) ? tag : (p ? "R1" : "R12"), {31'b0, rsp_err}, {31'b0, !(p && wd)});
            if (!w) check(tag, rsp_rdata, (p && wd) ? m_read(a) : 32'h0);
        end
        m_edge(v, w, p, wd, a, d, rt);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        cyc(tag, 1, 0, 1, 1, a, 32'h0, 1'b0);
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
        cyc(tag, 1, 1, 1, 1, a, d, 1'b0);
    endtask

    task automatic idle(input int n, input bit rt);
        for (int i = 0; i < n; i++) cyc("R6", 0, 0, 1, 1, 8'h00, 32'h0, rt);
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        {m_en, m_ie, m_cs, m_flag, m_run, m_irq} = '0;
        m_cnt = '0; m_rld = '0;

        // R13: reset state; R10: forced source bit on the no-reference instance
        rd("R13", 8'h00);
        check("R10", nr_last, 32'h0000_0004);
        rd("R13", 8'h04);
        rd("R13", 8'h08);
        wr("R2", 8'h00, 32'h0);
        rd("R2", 8'h00);
        check("R10", nr_last, 32'h0000_0004);
        rd("R11", 8'h0C);
        check("R11", nr_last, 32'h8000_0000);

        // R2: only bits [2:0] are writable
        wr("R2", 8'h00, 32'hFFFF_FFF8);
        rd("R2", 8'h00);
        check("R10", nr_last, 32'h0000_0004);

        // R4: reload keeps 24 bits
        wr("R4", 8'h04, 32'hFFAB_CDEF);
        rd("R4", 8'h04);

        // R6 and R7: core clock counting with interrupts
        wr("R4", 8'h04, 32'h3);
        wr("R6", 8'h00, 32'h7);
        for (int i = 0; i < 10; i++) rd("R6", 8'h08);
        idle(3, 1'b0);
        rd("R3", 8'h00);
        rd("R3", 8'h00);

        // R5: current-value write zeroes and clears the flag; R8: reload from zero
        idle(2, 1'b0);
        wr("R5", 8'h08, 32'h1234_5678);
        rd("R8", 8'h08);
        rd("R5", 8'h00);
        rd("R8", 8'h08);

        // R9: zero reload halts with enable still set
        wr("R9", 8'h04, 32'h0);
        idle(8, 1'b0);
        rd("R9", 8'h08);
        rd("R9", 8'h00);
        wr("R9", 8'h04, 32'h2);
        wr("R9", 8'h00, 32'h7);
        idle(4, 1'b0);
        rd("R9", 8'h08);
        wr("R9", 8'h00, 32'h6);
        wr("R9", 8'h00, 32'h7);
        for (int i = 0; i < 6; i++) rd("R9", 8'h08);

        // R6: reference-tick counting
        wr("R6", 8'h04, 32'h4);
        wr("R6", 8'h00, 32'h3);
        for (int i = 0; i < 12; i++) cyc("R6", 1, 0, 1, 1, 8'h08, 32'h0, (i % 3) == 0);

        // R12 and R1: refused accesses change nothing
        cyc("R12", 1, 1, 0, 1, 8'h04, 32'h55, 1'b0);
        cyc("R12", 1, 0, 0, 1, 8'h00, 32'h0, 1'b0);
        rd("R12", 8'h04);
        cyc("R1", 1, 1, 1, 0, 8'h00, 32'h0, 1'b0);
        rd("R1", 8'h00);

        // R14: unmapped offsets
        rd("R14", 8'h10);
        rd("R14", 8'h06);
        wr("R14", 8'h14, 32'hFFFF_FFFF);
        rd("R14", 8'h04);
        rd("R14", 8'h00);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            bit v, w, p, wd, rt;
            case ($urandom % 6)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h08;
                3: a = 8'h0C;
                4: a = 8'h10;
                default: a = 8'h03;
            endcase
            v  = ($urandom % 3) != 0;
            w  = ($urandom % 3) == 0;
            p  = ($urandom % 10) != 0;
            wd = ($urandom % 10) != 0;
            rt = ($urandom % 3) == 0;
            d  = $urandom;
            if (a == 8'h04) d = {d[31:24], 20'h0, 4'(d[3:0] % 13)};
            if (a == 8'h08 && ($urandom % 4) != 0) w = 1'b0;
            cyc(tag_of(a), v, w, p, wd, a, d, rt);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule